// File: doc/BRIEF.md
# Turn-Synchronized Bucket Sequencer Hold Control

The block keeps a bucket index that advances by one on every clock of the bunch clock domain and wraps once per machine revolution. At a programmable bucket it raises an internal once-per-turn marker. That marker sets where the outputs fall in time relative to the external revolution pulse.

In sync mode the block compares its internal marker with the external revolution pulse, after a two-flop synchronizer. If the two do not land on the same clock edge, the index freezes on the marker bucket and the block flags the loss of sync. It stays frozen until the external pulse next arrives, then continues from the bucket after the marker, which puts it back in step. In freerun mode the index cycles without any check. A requested mode change is applied only where the index wraps, so no turn is ever cut short.

Top module: `turn_sequencer`

## Requirements
- R1: While running, `bucket_o` rises by one per clock from 0 to TURN_LEN-1 (default 1113 buckets) and then wraps to 0. It never leaves that range.
- R2: `ref_pulse_o` is high exactly in the cycles where the block is not holding and `bucket_o` equals `ref_pos_i`. A `ref_pos_i` of TURN_LEN or more never produces a pulse.
- R3: `ext_sync_i` passes through two flops. A level sampled on clock edge k is the one compared on edge k+2. In sync mode, a synchronized high on the edge where the marker fires counts as coincidence, and counting goes on without a hold.
- R4: In sync mode, if the synchronized sync is low on the edge where the marker fires, the block enters hold. `bucket_o` then stays at the marker bucket.
- R5: `hold_o` is high for every cycle the index is frozen. `sync_lost_o` is high for exactly one cycle after each entry into hold.
- R6: While holding, a synchronized sync high on an edge ends the hold on that edge. `bucket_o` becomes the held bucket plus one, wrapping to 0 after TURN_LEN-1.
- R7: In freerun mode the index never holds and counts continuously, whatever `ext_sync_i` does.
- R8: `free_mode_i` (1 = freerun, 0 = sync) is taken only on an edge where the index steps from TURN_LEN-1 to 0. A change in mid-turn does not alter the handling of that turn's marker.
- R9: After a synchronous reset, `bucket_o` is 0, `hold_o` and `sync_lost_o` are low, the synchronizer is cleared and sync mode is selected.
- R10: While running in sync mode, a synchronized sync pulse on any bucket other than the marker has no effect on the index or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock; one bucket per cycle |
| rst | input | 1 | Synchronous active-high reset |
| ext_sync_i | input | 1 | External once-per-turn pulse, asynchronous |
| free_mode_i | input | 1 | Mode request: 1 freerun, 0 sync |
| ref_pos_i | input | CNT_W | Bucket at which the internal marker fires |
| bucket_o | output | CNT_W | Current bucket index |
| ref_pulse_o | output | 1 | Internal once-per-turn marker |
| hold_o | output | 1 | Index frozen awaiting external sync |
| sync_lost_o | output | 1 | One-cycle pulse on each entry into hold |

## Verification
The bench tries the function with several sync patterns. With no external sync at all, the first marker must hold. With pulses placed two buckets ahead of the marker, the block must never hold, which confirms the synchronizer latency. A stray pulse in mid-turn must change nothing. Late pulses must release the hold at the right bucket. Changing the mode before the marker and after it tells a wrap-point mode update apart from an immediate one. Markers placed at the last bucket, at bucket zero and beyond the turn test the wrap on release and the case where no marker can fire.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int unsigned TURN_LEN_DEF = 1113;
    localparam int unsigned SYNC_STAGES_DEF = 2;

    typedef enum logic {
        MODE_SYNC = 1'b0,
        MODE_FREE = 1'b1
    } seq_mode_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic advance;
        logic marker;
        logic enter_hold;
        logic release_hold;
    } seq_ctrl_t;

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/bucket_counter.sv
module bucket_counter #(
    parameter int unsigned TURN_LEN = 1113,
    localparam int unsigned CNT_W = $clog2(TURN_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance_i,
    output logic [CNT_W-1:0] bucket_o,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TURN_LEN - 1);

    logic [CNT_W-1:0] cnt_q;

    assign last_o   = (cnt_q == LAST);
    assign bucket_o = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (advance_i) begin
            cnt_q <= last_o ? '0 : cnt_q + 1'b1;
        end
    end

    // R1: the index stays inside the turn
    a_r1_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R1: stepping from the last bucket lands on bucket zero
    a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
        (advance_i && cnt_q == LAST) |=> (cnt_q == '0));

    // R4: no advance request means the index is frozen
    a_r4_frozen: assert property (@(posedge clk) disable iff (rst)
        !advance_i |=> $stable(cnt_q));

endmodule

// File: rtl/hold_ctrl.sv
module hold_ctrl
    import seq_pkg::*;
#(
    parameter int unsigned TURN_LEN = 1113,
    localparam int unsigned CNT_W = $clog2(TURN_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] bucket_i,
    input  logic             last_i,
    input  logic [CNT_W-1:0] ref_pos_i,
    input  logic             sync_i,
    input  logic             free_req_i,
    output logic             advance_o,
    output logic             marker_o,
    output logic             hold_o,
    output logic             lost_o
);
    seq_state_e state_q;
    seq_mode_e  mode_q;
    logic       lost_q;
    seq_ctrl_t  ctl;

    always_comb begin
        ctl              = '0;
        ctl.marker       = (state_q == ST_RUN) && (bucket_i == ref_pos_i);
        ctl.enter_hold   = ctl.marker && (mode_q == MODE_SYNC) && !sync_i;
        ctl.release_hold = (state_q == ST_HOLD) && sync_i;
        ctl.advance      = ((state_q == ST_RUN) && !ctl.enter_hold) ||
                           ctl.release_hold;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            mode_q  <= MODE_SYNC;
            lost_q  <= 1'b0;
        end else begin
            lost_q <= ctl.enter_hold;
            if (ctl.enter_hold)        state_q <= ST_HOLD;
            else if (ctl.release_hold) state_q <= ST_RUN;
            if (ctl.advance && last_i)
                mode_q <= free_req_i ? MODE_FREE : MODE_SYNC;
        end
    end

    assign advance_o = ctl.advance;
    assign marker_o  = ctl.marker;
    assign hold_o    = (state_q == ST_HOLD);
    assign lost_o    = lost_q;

    // R4: a missed marker in sync mode freezes and flags
    a_r4_enter: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && mode_q == MODE_SYNC && bucket_i == ref_pos_i && !sync_i)
        |=> (hold_o && lost_o && bucket_i == $past(bucket_i)));

    // R5: the loss flag never lasts two cycles
    a_r5_lost_single: assert property (@(posedge clk) disable iff (rst)
        lost_o |=> !lost_o);

    // R5: the loss flag only appears together with hold
    a_r5_lost_with_hold: assert property (@(posedge clk) disable iff (rst)
        lost_o |-> hold_o);

    // R6: a synchronized pulse during hold releases it
    a_r6_release: assert property (@(posedge clk) disable iff (rst)
        (hold_o && sync_i) |=> !hold_o);

    // R7: freerun never holds once a hold has been left
    a_r7_free_nohold: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_FREE && !hold_o) |=> !hold_o);

    // R8: the mode only changes on the wrap step
    a_r8_mode_at_wrap: assert property (@(posedge clk) disable iff (rst)
        !(advance_o && last_i) |=> $stable(mode_q));

    // R2: no marker while frozen
    a_r2_no_marker_in_hold: assert property (@(posedge clk) disable iff (rst)
        hold_o |-> !marker_o);

endmodule

// File: rtl/turn_sequencer.sv
module turn_sequencer
    import seq_pkg::*;
#(
    parameter int unsigned TURN_LEN = TURN_LEN_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
    localparam int unsigned CNT_W = $clog2(TURN_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_sync_i,
    input  logic             free_mode_i,
    input  logic [CNT_W-1:0] ref_pos_i,
    output logic [CNT_W-1:0] bucket_o,
    output logic             ref_pulse_o,
    output logic             hold_o,
    output logic             sync_lost_o
);
    logic             sync_s;
    logic             advance;
    logic             last;
    logic [CNT_W-1:0] bucket;

    sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (ext_sync_i),
        .sync_o  (sync_s)
    );

    bucket_counter #(.TURN_LEN(TURN_LEN)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .advance_i (advance),
        .bucket_o  (bucket),
        .last_o    (last)
    );

    hold_ctrl #(.TURN_LEN(TURN_LEN)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .bucket_i   (bucket),
        .last_i     (last),
        .ref_pos_i  (ref_pos_i),
        .sync_i     (sync_s),
        .free_req_i (free_mode_i),
        .advance_o  (advance),
        .marker_o   (ref_pulse_o),
        .hold_o     (hold_o),
        .lost_o     (sync_lost_o)
    );

    assign bucket_o = bucket;

    // R6: release resumes at the bucket after the held one
    a_r6_resume: assert property (@(posedge clk) disable iff (rst)
        (hold_o && sync_s) |=>
        (bucket_o == (($past(bucket_o) == CNT_W'(TURN_LEN - 1)) ? '0 : $past(bucket_o) + 1'b1)));

endmodule

// File: tb/sim_turn_sequencer.sv
module sim_turn_sequencer;
    localparam int L = 1113;
    localparam int W = $clog2(L);

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ext_sync = 1'b0;
    logic         free_mode = 1'b0;
    logic [W-1:0] ref_pos = '0;
    logic [W-1:0] bucket;
    logic         ref_pulse, hold, lost;

    turn_sequencer u0 (
        .clk(clk), .rst(rst), .ext_sync_i(ext_sync), .free_mode_i(free_mode),
        .ref_pos_i(ref_pos), .bucket_o(bucket), .ref_pulse_o(ref_pulse),
        .hold_o(hold), .sync_lost_o(lost)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural expectation, written from the requirements
    typedef struct { int cnt; bit hold; bit lost; } exp_t;
    exp_t q[$];
    int  m_cnt = 0;
    bit  m_hold = 0, m_lost = 0, m_free = 0, m_s1 = 0, m_s2 = 0;

    always @(posedge clk) begin
        exp_t e;
        if (rst) begin
            m_cnt = 0; m_hold = 0; m_lost = 0; m_free = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            bit s_now;
            s_now = m_s2;
            m_s2 = m_s1;
            m_s1 = ext_sync;
            m_lost = 0;
            if (!m_hold) begin
                if (!m_free && m_cnt == int'(ref_pos) && !s_now) begin
                    m_hold = 1; m_lost = 1;
                end else begin
                    if (m_cnt == L-1) begin m_cnt = 0; m_free = free_mode; end
                    else m_cnt = m_cnt + 1;
                end
            end else if (s_now) begin
                m_hold = 0;
                if (m_cnt == L-1) begin m_cnt = 0; m_free = free_mode; end
                else m_cnt = m_cnt + 1;
            end
        end
        e.cnt = m_cnt; e.hold = m_hold; e.lost = m_lost;
        q.push_back(e);
    end

    int hold_cycles = 0;
    int lost_seen = 0;
    int ref_seen = 0;

    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check("R1", "bucket", int'(bucket), e.cnt);
            check("R5", "hold", int'(hold), int'(e.hold));
            check("R5", "sync_lost", int'(lost), int'(e.lost));
            check("R2", "ref_pulse", int'(ref_pulse), int'(!e.hold && e.cnt == int'(ref_pos)));
            if (hold) hold_cycles++;
            if (lost) lost_seen++;
            if (ref_pulse) ref_seen++;
        end
    end

    // Driver: aligned pulses two buckets ahead of the marker, plus one-shot pulses
    bit auto_align = 0;
    bit manual = 0;
    always @(negedge clk) begin
        int pre2;
        pre2 = (int'(ref_pos) + L - 2) % L;
        ext_sync = manual || (auto_align && !m_hold && m_cnt == pre2);
        manual = 0;
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_bucket(input int b);
        for (int i = 0; i < 4*L && int'(bucket) != b; i++) @(negedge clk);
    endtask

    task automatic wait_hold(input bit lvl);
        for (int i = 0; i < 4*L && hold != lvl; i++) @(negedge clk);
    endtask

    task automatic pulse_once();
        @(negedge clk); #1 manual = 1;
    endtask

    initial begin
        wait_cycles(3);
        // R9: reset state
        check("R9", "bucket after reset", int'(bucket), 0);
        check("R9", "hold after reset", int'(hold), 0);
        check("R9", "lost after reset", int'(lost), 0);
        rst = 0;
        ref_pos = W'(5);

        // R4: no sync at all -> hold at marker
        wait_cycles(20);
        check("R4", "hold with no sync", int'(hold), 1);
        check("R4", "bucket held at marker", int'(bucket), 5);
        check("R5", "one loss pulse", lost_seen, 1);
        wait_cycles(30);
        check("R4", "still frozen", int'(bucket), 5);

        // R6: release on the next pulse
        pulse_once();
        wait_hold(0);
        check("R6", "bucket after release", int'(bucket), 6);

        // R3: aligned pulses keep running
        auto_align = 1;
        hold_cycles = 0;
        wait_cycles(2*L + 10);
        check("R3", "no hold with aligned sync", hold_cycles, 0);

        // R10: stray pulse in mid-turn
        wait_bucket(500);
        pulse_once();
        wait_cycles(40);
        check("R10", "stray pulse no hold", int'(hold), 0);
        check("R10", "index kept counting", int'(bucket), 541);

        // R3: misaligned sync -> hold, then resync
        auto_align = 0;
        wait_hold(1);
        check("R3", "mismatch holds", int'(bucket), 5);
        wait_cycles(100);
        pulse_once();
        wait_hold(0);
        check("R6", "resync bucket", int'(bucket), 6);

        // R8: freerun requested before the marker of a sync turn
        auto_align = 1;
        wait_bucket(1);
        free_mode = 1;
        auto_align = 0;
        wait_cycles(10);
        check("R8", "mid-turn request not applied", int'(hold), 1);
        pulse_once();
        wait_hold(0);
        // R7: next turns in freerun ignore missing and stray sync
        wait_bucket(0);
        hold_cycles = 0;
        wait_bucket(300);
        pulse_once();
        wait_cycles(2*L);
        check("R7", "freerun never holds", hold_cycles, 0);

        // R8: back to sync in mid-turn; applied after the wrap
        wait_bucket(300);
        free_mode = 0;
        wait_cycles(200);
        check("R8", "still free this turn", int'(hold), 0);
        wait_hold(1);
        check("R8", "sync applied next turn", int'(bucket), 5);
        pulse_once();
        wait_hold(0);

        // R6: release at the last bucket wraps to zero
        ref_pos = W'(L-1);
        wait_hold(1);
        check("R4", "hold at last bucket", int'(bucket), L-1);
        pulse_once();
        wait_hold(0);
        check("R6", "release wraps to zero", int'(bucket), 0);

        // R2: marker at bucket zero
        ref_pos = W'(0);
        wait_hold(1);
        check("R4", "hold at bucket zero", int'(bucket), 0);
        pulse_once();
        wait_hold(0);
        check("R6", "release from zero", int'(bucket), 1);

        // R2: marker outside the turn never fires
        ref_pos = W'(2000);
        ref_seen = 0;
        hold_cycles = 0;
        wait_cycles(2*L);
        check("R2", "no marker out of range", ref_seen, 0);
        check("R2", "no hold out of range", hold_cycles, 0);

        wait_cycles(4);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule